// File: doc/BRIEF.md
# Vector Convoy Execution Sequencer

This block steps a convoy of mutually independent vector operations through two fully pipelined functional units, an adder and a multiplier, both modelled as fixed-latency delay lines that carry a valid bit and an element-index tag. A descriptor names the units the convoy uses and gives a total element count. The block splits that count into strips no longer than the maximum vector length. The first strip takes the leftover part and every later strip is full length. Each strip runs the convoy once.

Every strip pays a fixed loop overhead before it issues. It then sends one element index per clock into each active unit. It waits until the last result of the slowest active unit has come out, and only then moves on, so convoys never overlap. A running cycle counter measures the busy time of each sequence, including the start-up latency of the final operation.

The controller is a five-state machine. In IDLE it is ready for a descriptor. LOOP spends the per-strip overhead. ISSUE streams the element indices. DRAIN waits out the slowest latency. EMPTY is a single busy cycle for a sequence with no work.

The transitions are as follows:
- IDLE to LOOP on accepting a descriptor that has work.
- IDLE to EMPTY on accepting a descriptor with a count of zero or with no unit selected.
- LOOP to ISSUE after the last overhead cycle.
- ISSUE to DRAIN after the last element.
- DRAIN to LOOP when elements remain.
- DRAIN to IDLE when no elements remain.
- EMPTY to IDLE unconditionally.

Top module: `cvs_convoy_seq`

## Requirements
- R1: `desc_ready` is high exactly in the cycles in which the sequencer is idle. A descriptor is taken at a clock edge where `desc_valid` and `desc_ready` are both high, and `desc_ready` stays low in the following cycle. Descriptor inputs presented while `desc_ready` is low have no effect.
- R2: A count of n > 0 runs ceil(n/64) strips. The first strip has length n mod 64, or 64 when n is a multiple of 64, and every later strip has length 64. `strip_len` shows the current strip's length from the strip's first overhead cycle to its last cycle.
- R3: Each strip opens with exactly 15 overhead cycles, during which neither unit receives an issue.
- R4: After the overhead comes one issue cycle per element of the strip. In these cycles each selected unit sees its issue valid high, with indices 0, 1, ... up to the strip length minus 1, in consecutive cycles. An unselected unit sees no issue.
- R5: The adder presents each issued index on `add_res_idx`, with `add_res_valid` high, exactly 6 cycles after that index was issued.
- R6: The multiplier presents each issued index on `mul_res_idx`, with `mul_res_valid` high, exactly 7 cycles after that index was issued.
- R7: `strip_done` pulses for one cycle, in the cycle in which the last result of the slowest selected unit appears. A strip therefore lasts 15 + length + slowest latency cycles, and the next strip's overhead starts in the following cycle.
- R8: `seq_done` pulses together with the last strip's `strip_done`, and the sequencer is idle in the next cycle.
- R9: A descriptor whose count is 0, or that selects no unit, gives one busy cycle with `seq_done` high, no `strip_done` and no issues.
- R10: `cycle_count` is 0 in the first busy cycle after acceptance and rises by one each busy cycle. After the sequence ends it holds the total number of busy cycles, which is 1 for an empty sequence.
- R11: A synchronous active-high `rst` empties both unit pipelines, ends any sequence in progress and clears `cycle_count`. In the cycle after reset, `desc_ready` is high and every valid and done output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer idle, descriptor can be taken |
| desc_use_add | input | 1 | Convoy uses the adder |
| desc_use_mul | input | 1 | Convoy uses the multiplier |
| desc_count | input | 16 | Total element count |
| strip_len | output | 7 | Current strip length |
| add_issue_valid | output | 1 | Element issued to the adder |
| add_issue_idx | output | 6 | Index issued to the adder |
| mul_issue_valid | output | 1 | Element issued to the multiplier |
| mul_issue_idx | output | 6 | Index issued to the multiplier |
| add_res_valid | output | 1 | Adder result emerging |
| add_res_idx | output | 6 | Tag of the emerging adder result |
| mul_res_valid | output | 1 | Multiplier result emerging |
| mul_res_idx | output | 6 | Tag of the emerging multiplier result |
| strip_done | output | 1 | Last result of the strip emerging |
| seq_done | output | 1 | Whole sequence complete |
| cycle_count | output | 32 | Busy-cycle counter of the current or last sequence |

## Verification
The checker assumes that `rst` is high in the first cycle, so that no property sees the values from before the first edge. It also assumes that the loop overhead exceeds both latencies, so that the results of one strip never share cycles with the issues of the next. The stimulus starts under reset and keeps the default parameters. It holds each descriptor stable from the moment it is offered until it is taken. It offers the next descriptor at once, while the sequencer is still busy, so the ignored-while-busy case is exercised on every back-to-back pair. A reset in mid-sequence is applied while the descriptor input is low, so no acceptance coincides with it.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOP,
        ST_ISSUE,
        ST_DRAIN,
        ST_EMPTY
    } seq_state_t;

    // Latency of the slowest selected unit; zero when none is selected.
    function automatic int slowest_lat(logic use_a, logic use_m, int lat_a, int lat_m);
        int r;
        r = 0;
        if (use_a && lat_a > r) r = lat_a;
        if (use_m && lat_m > r) r = lat_m;
        return r;
    endfunction

endpackage

// File: rtl/cvs_unit_pipe.sv
module cvs_unit_pipe #(
    parameter int DEPTH = 6,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign out_valid = in_valid;
            assign out_tag   = in_tag;
        end else begin : g_regs
            logic             v_q [DEPTH];
            logic [TAG_W-1:0] t_q [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        v_q[i] <= 1'b0;
                        t_q[i] <= '0;
                    end
                end else begin
                    v_q[0] <= in_valid;
                    t_q[0] <= in_tag;
                    for (int i = 1; i < DEPTH; i++) begin
                        v_q[i] <= v_q[i-1];
                        t_q[i] <= t_q[i-1];
                    end
                end
            end

            assign out_valid = v_q[DEPTH-1];
            assign out_tag   = t_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/cvs_strip_calc.sv
module cvs_strip_calc #(
    parameter int MAX_VL = 64,
    parameter int CNT_W  = 16,
    parameter int VL_W   = 7
) (
    input  logic [CNT_W-1:0] total,
    output logic [VL_W-1:0]  first_len,
    output logic [CNT_W-1:0] after_first
);

    logic [CNT_W-1:0] part;

    always_comb begin
        part = total % CNT_W'(MAX_VL);
        if (part == '0) begin
            first_len = VL_W'(MAX_VL);
        end else begin
            first_len = VL_W'(part);
        end
        after_first = total - CNT_W'(first_len);
    end

endmodule

// File: rtl/cvs_convoy_seq.sv
module cvs_convoy_seq
    import cvs_pkg::*;
#(
    parameter int MAX_VL   = 64,
    parameter int ADD_LAT  = 6,
    parameter int MUL_LAT  = 7,
    parameter int LOOP_OVH = 15,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = $clog2(MAX_VL),
    localparam int VL_W    = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic             desc_use_add,
    input  logic             desc_use_mul,
    input  logic [CNT_W-1:0] desc_count,
    output logic [VL_W-1:0]  strip_len,
    output logic             add_issue_valid,
    output logic [IDX_W-1:0] add_issue_idx,
    output logic             mul_issue_valid,
    output logic [IDX_W-1:0] mul_issue_idx,
    output logic             add_res_valid,
    output logic [IDX_W-1:0] add_res_idx,
    output logic             mul_res_valid,
    output logic [IDX_W-1:0] mul_res_idx,
    output logic             strip_done,
    output logic             seq_done,
    output logic [31:0]      cycle_count
);

    localparam int MAX_LAT = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
    localparam int DR_W    = $clog2(MAX_LAT + 1);
    localparam int OVH_W   = $clog2(LOOP_OVH + 1);

    seq_state_t       state_q, state_d;
    logic [OVH_W-1:0] ovh_q;
    logic [IDX_W-1:0] elem_q;
    logic [DR_W-1:0]  drain_q;
    logic [DR_W-1:0]  lat_q;
    logic [VL_W-1:0]  vl_q;
    logic [CNT_W-1:0] rem_q;
    logic             use_add_q, use_mul_q;
    logic [31:0]      cnt_q;

    logic [VL_W-1:0]  first_len;
    logic [CNT_W-1:0] after_first;
    logic             accept, no_work;
    logic             last_ovh, last_elem, last_drain, rem_zero;

    cvs_strip_calc #(
        .MAX_VL (MAX_VL),
        .CNT_W  (CNT_W),
        .VL_W   (VL_W)
    ) u_strip (
        .total       (desc_count),
        .first_len   (first_len),
        .after_first (after_first)
    );

    assign accept     = desc_valid && (state_q == ST_IDLE);
    assign no_work    = (desc_count == '0) || !(desc_use_add || desc_use_mul);
    assign last_ovh   = (ovh_q == OVH_W'(LOOP_OVH - 1));
    assign last_elem  = (VL_W'(elem_q) == vl_q - VL_W'(1));
    assign last_drain = (drain_q == lat_q - DR_W'(1));
    assign rem_zero   = (rem_q == '0);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = no_work ? ST_EMPTY : ST_LOOP;
            ST_LOOP:  if (last_ovh) state_d = ST_ISSUE;
            ST_ISSUE: if (last_elem) state_d = ST_DRAIN;
            ST_DRAIN: if (last_drain) state_d = rem_zero ? ST_IDLE : ST_LOOP;
            ST_EMPTY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counters and strip bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            ovh_q     <= '0;
            elem_q    <= '0;
            drain_q   <= '0;
            lat_q     <= '0;
            vl_q      <= '0;
            rem_q     <= '0;
            use_add_q <= 1'b0;
            use_mul_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        use_add_q <= desc_use_add;
                        use_mul_q <= desc_use_mul;
                        ovh_q     <= '0;
                        if (!no_work) begin
                            vl_q  <= first_len;
                            rem_q <= after_first;
                            lat_q <= DR_W'(slowest_lat(desc_use_add, desc_use_mul,
                                                       ADD_LAT, MUL_LAT));
                        end
                    end
                end
                ST_LOOP: begin
                    ovh_q  <= ovh_q + OVH_W'(1);
                    elem_q <= '0;
                end
                ST_ISSUE: begin
                    elem_q  <= elem_q + IDX_W'(1);
                    drain_q <= '0;
                end
                ST_DRAIN: begin
                    drain_q <= drain_q + DR_W'(1);
                    if (last_drain && !rem_zero) begin
                        vl_q  <= VL_W'(MAX_VL);
                        rem_q <= rem_q - CNT_W'(MAX_VL);
                        ovh_q <= '0;
                    end
                end
                ST_EMPTY: begin
                end
                default: begin
                end
            endcase

            if (state_q == ST_IDLE) begin
                if (accept) cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 32'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        desc_ready      = (state_q == ST_IDLE);
        add_issue_valid = (state_q == ST_ISSUE) && use_add_q;
        mul_issue_valid = (state_q == ST_ISSUE) && use_mul_q;
        add_issue_idx   = elem_q;
        mul_issue_idx   = elem_q;
        strip_done      = (state_q == ST_DRAIN) && last_drain;
        seq_done        = ((state_q == ST_DRAIN) && last_drain && rem_zero) ||
                          (state_q == ST_EMPTY);
        strip_len       = vl_q;
        cycle_count     = cnt_q;
    end

    cvs_unit_pipe #(
        .DEPTH (ADD_LAT),
        .TAG_W (IDX_W)
    ) u_add_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (add_issue_valid),
        .in_tag    (add_issue_idx),
        .out_valid (add_res_valid),
        .out_tag   (add_res_idx)
    );

    cvs_unit_pipe #(
        .DEPTH (MUL_LAT),
        .TAG_W (IDX_W)
    ) u_mul_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (mul_issue_valid),
        .in_tag    (mul_issue_idx),
        .out_valid (mul_res_valid),
        .out_tag   (mul_res_idx)
    );

endmodule

// File: rtl/cvs_convoy_seq_chk.sv
module cvs_convoy_seq_chk #(
    parameter int IDX_W = 6,
    parameter int VL_W  = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [VL_W-1:0]  strip_len,
    input logic             add_issue_valid,
    input logic [IDX_W-1:0] add_issue_idx,
    input logic             mul_issue_valid,
    input logic [IDX_W-1:0] mul_issue_idx,
    input logic             add_res_valid,
    input logic             mul_res_valid,
    input logic             strip_done,
    input logic             seq_done,
    input logic [31:0]      cycle_count
);

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_ready |=> !desc_ready); // R1

    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        desc_ready |-> !(add_issue_valid || mul_issue_valid)); // R3

    AST_IDX_IN_STRIP: assert property (@(posedge clk) disable iff (rst)
        add_issue_valid |-> (VL_W'(add_issue_idx) < strip_len)); // R2

    AST_ADD_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && add_issue_valid && $past(add_issue_valid)
        |-> add_issue_idx == $past(add_issue_idx) + IDX_W'(1)); // R4

    AST_MUL_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && mul_issue_valid && $past(mul_issue_valid)
        |-> mul_issue_idx == $past(mul_issue_idx) + IDX_W'(1)); // R4

    AST_RES_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (add_res_valid || mul_res_valid) |-> !desc_ready); // R5

    AST_STRIP_END_QUIET: assert property (@(posedge clk) disable iff (rst)
        strip_done |-> !(add_issue_valid || mul_issue_valid)); // R7

    AST_SEQ_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done && desc_ready); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !desc_ready && !$past(desc_ready)
        |-> cycle_count == $past(cycle_count) + 32'd1); // R10

endmodule

bind cvs_convoy_seq cvs_convoy_seq_chk #(
    .IDX_W (IDX_W),
    .VL_W  (VL_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .desc_valid      (desc_valid),
    .desc_ready      (desc_ready),
    .strip_len       (strip_len),
    .add_issue_valid (add_issue_valid),
    .add_issue_idx   (add_issue_idx),
    .mul_issue_valid (mul_issue_valid),
    .mul_issue_idx   (mul_issue_idx),
    .add_res_valid   (add_res_valid),
    .mul_res_valid   (mul_res_valid),
    .strip_done      (strip_done),
    .seq_done        (seq_done),
    .cycle_count     (cycle_count)
);

// File: tb/cvs_convoy_seq_test.sv
module cvs_convoy_seq_test;

    localparam int MAXV = 64;
    localparam int OVH  = 15;
    localparam int LA   = 6;
    localparam int LM   = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic        desc_use_add = 1'b0;
    logic        desc_use_mul = 1'b0;
    logic [15:0] desc_count = '0;
    logic        desc_ready;
    logic [6:0]  strip_len;
    logic        add_issue_valid, mul_issue_valid, add_res_valid, mul_res_valid;
    logic [5:0]  add_issue_idx, mul_issue_idx, add_res_idx, mul_res_idx;
    logic        strip_done, seq_done;
    logic [31:0] cycle_count;

    cvs_convoy_seq uut (
        .clk             (clk),
        .rst             (rst),
        .desc_valid      (desc_valid),
        .desc_ready      (desc_ready),
        .desc_use_add    (desc_use_add),
        .desc_use_mul    (desc_use_mul),
        .desc_count      (desc_count),
        .strip_len       (strip_len),
        .add_issue_valid (add_issue_valid),
        .add_issue_idx   (add_issue_idx),
        .mul_issue_valid (mul_issue_valid),
        .mul_issue_idx   (mul_issue_idx),
        .add_res_valid   (add_res_valid),
        .add_res_idx     (add_res_idx),
        .mul_res_valid   (mul_res_valid),
        .mul_res_idx     (mul_res_idx),
        .strip_done      (strip_done),
        .seq_done        (seq_done),
        .cycle_count     (cycle_count)
    );

    always #4 clk = ~clk;  // 125 MHz

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit started = 0;
    bit was_rst = 0;
    int cnt_idle = 0;

    // Reference model: expectations keyed by absolute cycle number
    int e_busy[int];   // busy cycle -> expected cycle_count
    int e_vl[int];
    int e_ovh[int];
    int e_empty[int];
    int e_ai[int];
    int e_mi[int];
    int e_ar[int];
    int e_mr[int];
    int e_sd[int];
    int e_qd[int];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        started <= 1'b1;
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic plan(int c, int n, bit ua, bit um);
        int t, k, rem, vl, lat;
        t = c + 1;
        k = 0;
        if (n == 0 || !(ua || um)) begin
            e_busy[t] = 0;
            e_empty[t] = 1;
            e_qd[t] = 1;
            return;
        end
        lat = 0;
        if (ua && LA > lat) lat = LA;
        if (um && LM > lat) lat = LM;
        rem = n;
        vl = (n % MAXV == 0) ? MAXV : n % MAXV;
        while (rem > 0) begin
            for (int i = 0; i < OVH; i++) begin
                e_busy[t] = k; e_vl[t] = vl; e_ovh[t] = 1; t++; k++;
            end
            for (int i = 0; i < vl; i++) begin
                e_busy[t] = k; e_vl[t] = vl;
                if (ua) begin e_ai[t] = i; e_ar[t + LA] = i; end
                if (um) begin e_mi[t] = i; e_mr[t + LM] = i; end
                t++; k++;
            end
            for (int d = 0; d < lat; d++) begin
                e_busy[t] = k; e_vl[t] = vl;
                if (d == lat - 1) begin
                    e_sd[t] = 1;
                    if (rem == vl) e_qd[t] = 1;
                end
                t++; k++;
            end
            rem -= vl;
            vl = MAXV;
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            bit busy;
            string iss_req;
            busy = e_busy.exists(cyc);
            iss_req = e_ovh.exists(cyc) ? "R3" : "R4";
            chk(was_rst ? "R11" : "R1", "desc_ready", int'(desc_ready), int'(!busy));
            chk(was_rst ? "R11" : "R10", "cycle_count", int'(cycle_count),
                busy ? e_busy[cyc] : cnt_idle);
            if (e_vl.exists(cyc)) chk("R2", "strip_len", int'(strip_len), e_vl[cyc]);
            chk(iss_req, "add_issue_valid", int'(add_issue_valid), int'(e_ai.exists(cyc)));
            if (e_ai.exists(cyc)) chk("R4", "add_issue_idx", int'(add_issue_idx), e_ai[cyc]);
            chk(iss_req, "mul_issue_valid", int'(mul_issue_valid), int'(e_mi.exists(cyc)));
            if (e_mi.exists(cyc)) chk("R4", "mul_issue_idx", int'(mul_issue_idx), e_mi[cyc]);
            chk("R5", "add_res_valid", int'(add_res_valid), int'(e_ar.exists(cyc)));
            if (e_ar.exists(cyc)) chk("R5", "add_res_idx", int'(add_res_idx), e_ar[cyc]);
            chk("R6", "mul_res_valid", int'(mul_res_valid), int'(e_mr.exists(cyc)));
            if (e_mr.exists(cyc)) chk("R6", "mul_res_idx", int'(mul_res_idx), e_mr[cyc]);
            chk(e_empty.exists(cyc) ? "R9" : "R7", "strip_done", int'(strip_done),
                int'(e_sd.exists(cyc)));
            chk(e_empty.exists(cyc) ? "R9" : "R8", "seq_done", int'(seq_done),
                int'(e_qd.exists(cyc)));
            if (busy) cnt_idle = e_busy[cyc] + 1;

            if (rst) begin
                e_busy.delete(); e_vl.delete(); e_ovh.delete(); e_empty.delete();
                e_ai.delete(); e_mi.delete(); e_ar.delete(); e_mr.delete();
                e_sd.delete(); e_qd.delete();
                cnt_idle = 0;
            end else if (desc_valid && !busy) begin
                plan(cyc, int'(desc_count), desc_use_add, desc_use_mul);
            end
            was_rst = rst;

            if (cyc > 20000) begin
                n_fail++;
                $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
                finish_run();
            end
        end
    end

    task automatic send(int n, bit ua, bit um);
        bit taken;
        desc_valid = 1'b1;
        desc_count = 16'(n);
        desc_use_add = ua;
        desc_use_mul = um;
        do begin
            @(negedge clk);
            taken = desc_ready;
            @(posedge clk);
            #1;
        end while (!taken);
        desc_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        send(5, 1'b1, 1'b0);     // R4 short add-only strip
        send(64, 1'b0, 1'b1);    // R2 exact full strip
        send(70, 1'b1, 1'b1);    // R2 remainder first, then full strip
        send(0, 1'b1, 1'b1);     // R9 empty count
        send(10, 1'b0, 1'b0);    // R9 no unit selected
        send(130, 1'b1, 1'b0);   // R7 three strips
        send(1, 1'b1, 1'b1);     // single element
        send(128, 1'b0, 1'b1);   // two full strips
        send(40, 1'b1, 1'b1);    // R11 cut short by reset
        repeat (30) @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        send(3, 1'b0, 1'b1);
        repeat (200) @(posedge clk);
        #1 finish_run();
    end

endmodule